// File: doc/BRIEF.md
# Saved-Setting Store and Restore Sequencer

This block sequences timed accesses to a small emulated nonvolatile array that holds one saved setting per wiper channel and a bank of user bytes. It accepts single-cycle command requests that carry an address and data. Each command either saves a wiper setting, writes a user byte, restores wiper settings, or reads back a user byte or a saved setting. Storage cell physics are not modelled. Cycle counters stand in for the busy time of each command class, and a `ready` output is held low for that time.

After reset the block restores every channel on its own. A channel that has never been saved restores midscale. A rising edge on the hardware preset input, taken through a two-stage synchronizer, repeats that refresh. An active-low write-protect level blocks the two save commands. Restores and reads still run while it is low. A request that is illegal, or that arrives while the block is busy, is dropped and sets a sticky error flag.

Top module: `nv_restore_seq`

## Requirements
- R1: During reset and for PRESET_CYC cycles after its release, `ready` is low. In the cycle after `ready` rises, `restoreValid` is all ones and every channel's restored value is present on `restoreData` (channel c in bits c*10 upward).
- R2: A channel that has not been saved since reset restores and reads back midscale, 2^(DATA_W-1) = 512.
- R3: Opcode 0 saves `cmdData` as the setting of channel `cmdAddr`. `ready` stays low for STORE_CYC cycles, and later restores of that channel return the saved value.
- R4: Opcode 1 writes `cmdData[7:0]` to user byte `cmdAddr` (0..25) with STORE_CYC busy cycles. Opcode 4 reads that byte with READ_CYC busy cycles. `rdValid` pulses for one cycle with the byte zero-extended on `rdData`, in the cycle after `ready` rises. User bytes read 0 after reset.
- R5: Opcode 2 restores all channels with RESTORE_CYC busy cycles and signals as in R1.
- R6: Opcode 3 restores only channel `cmdAddr` without lowering `ready`. Only that bit of `restoreValid` pulses, two cycles after the request cycle.
- R7: Opcode 5 reads the effective setting of channel `cmdAddr` (saved value or midscale) with READ_CYC busy cycles, on `rdData`/`rdValid`.
- R8: A low-to-high transition of `presetPin` starts an all-channel refresh lasting PRESET_CYC cycles, with `ready` low from the third clock edge after the pin rises. A steady level or a falling edge does nothing.
- R9: While `wpN` is low, opcodes 0 and 1 are ignored. Nothing goes busy, no storage changes and no error is flagged. Restores and reads still run.
- R10: A request while `ready` is low is ignored and sets `errSticky`. The flag stays set until reset.
- R11: Opcodes 6 and 7, a channel address of 2 or more for opcodes 0, 3 and 5, and a user address of 26 or more are ignored and set `errSticky`.
- R12: A preset rising edge during a busy operation is held. The refresh starts when that operation ends, with `ready` staying low through both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle command request |
| cmdOp | input | 3 | Command opcode |
| cmdAddr | input | 5 | Channel or user-byte address |
| cmdData | input | 10 | Setting or byte to save |
| presetPin | input | 1 | Asynchronous preset, acts on rising edge |
| wpN | input | 1 | Write protect, active low |
| ready | output | 1 | High when idle |
| errSticky | output | 1 | Dropped-request flag |
| restoreData | output | 20 | Restored settings, one 10-bit field per channel |
| restoreValid | output | 2 | Per-channel restore strobe |
| rdData | output | 10 | Read-back value |
| rdValid | output | 1 | Read-back strobe |

## Verification
A wrong busy counter or a wrong busy-class decode shows up as a `ready` low interval that is off by cycles for one command class. The bench measures that interval for every class. A wrongly latched address or a missed save shows at the next restore or read of that slot, a few cycles later. For that reason every save is followed by a restore and a readback. Lost preset edges, a dropped pending refresh, and write-protect leaks show as a missing `ready` low interval, a short one, or a changed value on the next read.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [2:0] {
    OP_SAVE_WIPER  = 3'd0,
    OP_WRITE_USER  = 3'd1,
    OP_RESTORE_ALL = 3'd2,
    OP_RESTORE_ONE = 3'd3,
    OP_READ_USER   = 3'd4,
    OP_READ_SAVED  = 3'd5
  } nv_op_e;

  typedef struct packed {
    logic saveWiper;
    logic writeUser;
    logic restoreAll;
    logic restoreOne;
    logic readUser;
    logic readSaved;
  } nv_strobe_t;
endpackage

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl
  import nv_seq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int NUM_USER    = 26,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 10,
  parameter int STORE_CYC   = 1000000,
  parameter int RESTORE_CYC = 50000,
  parameter int READ_CYC    = 5000,
  parameter int PRESET_CYC  = 3500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              presetPin,
  input  logic              wpN,
  output logic              ready,
  output logic              errSticky,
  output nv_strobe_t        stb,
  output logic [ADDR_W-1:0] stbAddr,
  output logic [DATA_W-1:0] stbData
);
  localparam int MAX_A   = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
  localparam int MAX_B   = (READ_CYC > PRESET_CYC) ? READ_CYC : PRESET_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam nv_strobe_t K_RESTORE_ALL = '{restoreAll: 1'b1, default: 1'b0};

  logic [1:0]       presetSync;
  logic             presetPrev;
  logic             presetRise;
  logic             presetPend;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  nv_strobe_t       doneKind;

  logic isStore, isUserOp, isChanOp, opKnown, addrOk, legal, startCmd, cmdErr;
  nv_strobe_t reqKind;
  logic [CNT_W-1:0] reqDur;

  assign presetRise = presetSync[1] & ~presetPrev;

  always_comb begin
    isStore  = (cmdOp == OP_SAVE_WIPER) || (cmdOp == OP_WRITE_USER);
    isUserOp = (cmdOp == OP_WRITE_USER) || (cmdOp == OP_READ_USER);
    isChanOp = (cmdOp == OP_SAVE_WIPER) || (cmdOp == OP_RESTORE_ONE) || (cmdOp == OP_READ_SAVED);
    opKnown  = (cmdOp <= OP_READ_SAVED);
    addrOk   = isUserOp ? (cmdAddr < ADDR_W'(NUM_USER))
             : isChanOp ? (cmdAddr < ADDR_W'(NUM_CH)) : 1'b1;
    legal    = opKnown && addrOk;
    startCmd = !busy && cmdValid && !presetRise && legal && !(isStore && !wpN);
    cmdErr   = cmdValid && (busy || presetRise || !legal);
    reqKind  = '0;
    reqDur   = CNT_W'(READ_CYC - 1);
    case (cmdOp)
      OP_SAVE_WIPER:  begin reqKind.saveWiper  = 1'b1; reqDur = CNT_W'(STORE_CYC - 1);   end
      OP_WRITE_USER:  begin reqKind.writeUser  = 1'b1; reqDur = CNT_W'(STORE_CYC - 1);   end
      OP_RESTORE_ALL: begin reqKind.restoreAll = 1'b1; reqDur = CNT_W'(RESTORE_CYC - 1); end
      OP_RESTORE_ONE: reqKind.restoreOne = 1'b1;
      OP_READ_USER:   reqKind.readUser   = 1'b1;
      OP_READ_SAVED:  reqKind.readSaved  = 1'b1;
      default:        reqKind = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presetSync <= 2'b11;
      presetPrev <= 1'b1;
      presetPend <= 1'b0;
      busy       <= 1'b1;
      cnt        <= CNT_W'(PRESET_CYC - 1);
      doneKind   <= K_RESTORE_ALL;
      errSticky  <= 1'b0;
      stb        <= '0;
      stbAddr    <= '0;
      stbData    <= '0;
    end else begin
      stb        <= '0;
      presetSync <= {presetSync[0], presetPin};
      presetPrev <= presetSync[1];
      if (cmdErr) errSticky <= 1'b1;
      if (busy) begin
        if (cnt == '0) begin
          stb <= doneKind;
          if (presetPend || presetRise) begin
            cnt        <= CNT_W'(PRESET_CYC - 1);
            doneKind   <= K_RESTORE_ALL;
            presetPend <= 1'b0;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          cnt <= cnt - 1'b1;
          if (presetRise) presetPend <= 1'b1;
        end
      end else if (presetRise) begin
        busy     <= 1'b1;
        cnt      <= CNT_W'(PRESET_CYC - 1);
        doneKind <= K_RESTORE_ALL;
      end else if (startCmd) begin
        stbAddr <= cmdAddr;
        stbData <= cmdData;
        if (reqKind.restoreOne) begin
          stb <= reqKind;
        end else begin
          busy     <= 1'b1;
          cnt      <= reqDur;
          doneKind <= reqKind;
        end
      end
    end
  end

  assign ready = ~busy;

  p_busy_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !ready |=> errSticky);
  p_wp_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    ready && cmdValid && !wpN && isStore && !presetRise |=> ready);
  p_restore_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    ready && cmdValid && cmdOp == OP_RESTORE_ALL && !presetRise |=> !ready);
  p_preset_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready && presetRise |=> !ready);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));
endmodule

// File: rtl/nv_seq_store.sv
module nv_seq_store
  import nv_seq_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int NUM_USER = 26,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 10,
  parameter int USER_W   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  nv_strobe_t               stb,
  input  logic [ADDR_W-1:0]        stbAddr,
  input  logic [DATA_W-1:0]        stbData,
  output logic [NUM_CH*DATA_W-1:0] restoreData,
  output logic [NUM_CH-1:0]        restoreValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] savedVal  [NUM_CH];
  logic [DATA_W-1:0] effVal    [NUM_CH];
  logic [NUM_CH-1:0] programmed;
  logic [USER_W-1:0] userMem   [NUM_USER];
  logic [CH_W-1:0]   chIdx;

  assign chIdx = stbAddr[CH_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit       = (chIdx == CH_W'(c));
    assign effVal[c] = programmed[c] ? savedVal[c] : MID;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        savedVal[c]                        <= '0;
        programmed[c]                      <= 1'b0;
        restoreData[c*DATA_W +: DATA_W]    <= '0;
        restoreValid[c]                    <= 1'b0;
      end else begin
        if (stb.saveWiper && hit) begin
          savedVal[c]   <= stbData;
          programmed[c] <= 1'b1;
        end
        restoreValid[c] <= stb.restoreAll || (stb.restoreOne && hit);
        if (stb.restoreAll || (stb.restoreOne && hit))
          restoreData[c*DATA_W +: DATA_W] <= effVal[c];
      end
    end

    p_blank_mid_r2: assert property (@(posedge clk) disable iff (!rstN)
      restoreValid[c] && !programmed[c] |-> restoreData[c*DATA_W +: DATA_W] == MID);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_USER; i++) userMem[i] <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.readUser || stb.readSaved;
      if (stb.writeUser) userMem[stbAddr] <= stbData[USER_W-1:0];
      if (stb.readUser)  rdData <= DATA_W'(userMem[stbAddr]);
      if (stb.readSaved) rdData <= effVal[chIdx];
    end
  end

  p_one_result_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && (|restoreValid)));
endmodule

// File: rtl/nv_restore_seq.sv
module nv_restore_seq
  import nv_seq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int NUM_USER    = 26,
  parameter int DATA_W      = 10,
  parameter int USER_W      = 8,
  parameter int STORE_CYC   = 1000000,
  parameter int RESTORE_CYC = 50000,
  parameter int READ_CYC    = 5000,
  parameter int PRESET_CYC  = 3500,
  localparam int ADDR_W     = $clog2(NUM_USER)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [2:0]               cmdOp,
  input  logic [ADDR_W-1:0]        cmdAddr,
  input  logic [DATA_W-1:0]        cmdData,
  input  logic                     presetPin,
  input  logic                     wpN,
  output logic                     ready,
  output logic                     errSticky,
  output logic [NUM_CH*DATA_W-1:0] restoreData,
  output logic [NUM_CH-1:0]        restoreValid,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);
  nv_strobe_t        stb;
  logic [ADDR_W-1:0] stbAddr;
  logic [DATA_W-1:0] stbData;

  nv_seq_ctrl #(
    .NUM_CH(NUM_CH), .NUM_USER(NUM_USER), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC),
    .READ_CYC(READ_CYC), .PRESET_CYC(PRESET_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .presetPin(presetPin), .wpN(wpN),
    .ready(ready), .errSticky(errSticky), .stb(stb),
    .stbAddr(stbAddr), .stbData(stbData)
  );

  nv_seq_store #(
    .NUM_CH(NUM_CH), .NUM_USER(NUM_USER), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .USER_W(USER_W)
  ) store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .stbAddr(stbAddr), .stbData(stbData),
    .restoreData(restoreData), .restoreValid(restoreValid),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/nv_restore_seq_tb_top.sv
module nv_restore_seq_tb_top;
  localparam int ST = 40, RS = 12, RD = 5, PS = 8;
  localparam int MID = 512;

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0, presetPin = 1'b0, wpN = 1'b1;
  logic [2:0]  cmdOp = '0;
  logic [4:0]  cmdAddr = '0;
  logic [9:0]  cmdData = '0;
  logic        ready, errSticky, rdValid;
  logic [19:0] restoreData;
  logic [1:0]  restoreValid;
  logic [9:0]  rdData;

  int errors = 0, checks = 0;
  bit finished = 0;
  int lowCnt;
  logic [1:0]  rv;
  logic        rdv;
  logic [9:0]  rd;
  logic [19:0] rdat;

  always #10 clk = ~clk;

  nv_restore_seq #(.STORE_CYC(ST), .RESTORE_CYC(RS), .READ_CYC(RD), .PRESET_CYC(PS)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .presetPin(presetPin), .wpN(wpN), .ready(ready),
    .errSticky(errSticky), .restoreData(restoreData), .restoreValid(restoreValid),
    .rdData(rdData), .rdValid(rdValid)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(int op, int addr, int data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdAddr = 5'(addr); cmdData = 10'(data);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic measure();
    lowCnt = 0;
    while (!ready && lowCnt < 10000) begin
      lowCnt++;
      @(negedge clk);
    end
    @(negedge clk);
    rv = restoreValid; rdv = rdValid; rd = rdData; rdat = restoreData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmdValid = 1'b0; presetPin = 1'b0; wpN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", ready, 0);
    rstN = 1'b1;
    measure();
  endtask

  task automatic t_power_on();
    doReset();
    chk("R1 power-on busy cycles", lowCnt, PS);
    chk("R1 power-on restore valid", rv, 3);
    chk("R1 error clear after reset", errSticky, 0);
    chk("R2 blank ch0 midscale", rdat[9:0], MID);
    chk("R2 blank ch1 midscale", rdat[19:10], MID);
    issue(5, 1, 0); measure();
    chk("R2 blank read saved", rd, MID);
  endtask

  task automatic t_save_restore();
    issue(0, 0, 100); measure();
    chk("R3 save busy cycles", lowCnt, ST);
    chk("R3 save emits nothing", {rv, rdv}, 0);
    issue(0, 1, 1023); measure();
    issue(2, 0, 0); measure();
    chk("R5 restore-all busy", lowCnt, RS);
    chk("R5 restore-all valid", rv, 3);
    chk("R3 ch0 saved value", rdat[9:0], 100);
    chk("R3 ch1 saved value", rdat[19:10], 1023);
  endtask

  task automatic t_restore_one();
    issue(3, 1, 0); measure();
    chk("R6 restore-one no busy", lowCnt, 0);
    chk("R6 restore-one single bit", rv, 2);
    chk("R6 restore-one value", rdat[19:10], 1023);
  endtask

  task automatic t_user();
    issue(1, 25, 10'h0A5); measure();
    chk("R4 write busy", lowCnt, ST);
    issue(4, 25, 0); measure();
    chk("R4 read busy", lowCnt, RD);
    chk("R4 read valid", rdv, 1);
    chk("R4 read byte", rd, 10'h0A5);
    issue(4, 3, 0); measure();
    chk("R4 unwritten byte zero", rd, 0);
  endtask

  task automatic t_read_saved();
    issue(5, 0, 0); measure();
    chk("R7 read saved busy", lowCnt, RD);
    chk("R7 read saved value", rd, 100);
    chk("R7 read valid", rdv, 1);
  endtask

  task automatic t_write_protect();
    wpN = 1'b0;
    issue(0, 0, 300); measure();
    chk("R9 blocked save no busy", lowCnt, 0);
    chk("R9 blocked save no output", {rv, rdv}, 0);
    issue(1, 25, 10'h011); measure();
    chk("R9 blocked write no busy", lowCnt, 0);
    chk("R9 no error", errSticky, 0);
    issue(3, 0, 0); measure();
    chk("R9 restore proceeds", rv, 1);
    chk("R9 saved value kept", rdat[9:0], 100);
    issue(4, 25, 0); measure();
    chk("R9 user byte kept", rd, 10'h0A5);
    wpN = 1'b1;
  endtask

  task automatic t_preset();
    @(negedge clk); presetPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R8 ready still high before sync", ready, 1);
    @(negedge clk);
    measure();
    chk("R8 preset busy", lowCnt, PS);
    chk("R8 preset restore valid", rv, 3);
    chk("R8 preset value", rdat[9:0], 100);
    repeat (4) @(negedge clk);
    chk("R8 steady high no action", ready, 1);
    presetPin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 falling edge no action", ready, 1);
  endtask

  task automatic t_preset_pending();
    issue(2, 0, 0);
    presetPin = 1'b1;
    measure();
    chk("R12 chained busy", lowCnt, RS + PS);
    chk("R12 refresh valid", rv, 3);
    presetPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_errors();
    chk("R10 no error yet", errSticky, 0);
    issue(7, 0, 0); measure();
    chk("R11 bad opcode no busy", lowCnt, 0);
    chk("R11 bad opcode flag", errSticky, 1);
    doReset();
    chk("R10 reset clears flag", errSticky, 0);
    issue(4, 26, 0); measure();
    chk("R11 bad user addr no output", rdv, 0);
    chk("R11 bad user addr flag", errSticky, 1);
    doReset();
    issue(0, 2, 7); measure();
    chk("R11 bad channel no busy", lowCnt, 0);
    chk("R11 bad channel flag", errSticky, 1);
    doReset();
    issue(2, 0, 0);
    cmdValid = 1'b1; cmdOp = 3'd4; cmdAddr = 5'd0;
    @(negedge clk); cmdValid = 1'b0;
    measure();
    chk("R10 busy unchanged", lowCnt, RS - 1);
    chk("R10 only restore result", {rv, rdv}, 3'b110);
    chk("R10 flag set", errSticky, 1);
    @(negedge clk);
    chk("R10 dropped read absent", rdv, 0);
  endtask

  initial begin
    t_power_on();
    t_save_restore();
    t_restore_one();
    t_user();
    t_read_saved();
    t_write_protect();
    t_preset();
    t_preset_pending();
    t_errors();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule